// File: doc/BRIEF.md
# MDIO Management Slave

This block is the device side of a clause-22 serial management bus. It samples the shared data line on each rising edge of the management clock and waits for a run of ones followed by the start pattern. It then decodes a two-bit opcode, a five-bit device address and a five-bit register address. The device address is compared with an address taken from strap inputs while reset is held.

A matching read frame returns one of 32 sixteen-bit registers. The slave leaves the line alone for the first turnaround bit, drives a zero for the second, and then shifts the word out most significant bit first. A matching write frame shifts in sixteen bits, updates the register bank, and shows the update on a one-cycle write strobe. The first clock edge after reset is never used. Malformed frames send the slave back to searching for the preamble. A combinational host read port exposes the register bank to the rest of the chip.

Top module: `mdio_slave`

## Requirements
- R1: While reset is low, the output enable is low, every register reads back zero on the host port, and the strap address is captured.
- R2: The first rising clock edge after reset is released is ignored, so a one sampled there does not count toward the preamble.
- R3: A frame is accepted only after at least 32 consecutive ones followed by the start bits 0 then 1; a run of 31 ones is not enough.
- R4: For a matching read (opcode bits 1 then 0), the output enable rises after the edge that samples turnaround bit one with the output at 0. The 16 data bits follow MSB first, one per edge, and the enable falls after the edge that samples the last data bit.
- R5: For a matching write (opcode bits 0 then 1), the 16 bits after the turnaround are taken MSB first. The write strobe is high for exactly the cycle that ends with the last data edge, carrying the register address and data, and the register then reads back that value on the host port.
- R6: In 5-bit address mode, a frame whose address differs from the strap address never drives the line and never writes a register.
- R7: In 4-bit address mode, a frame matches only when the top bit of the 5-bit address field is 0 and the low four bits equal the strap address.
- R8: An opcode of 00 or 11 ends the frame with no bus activity, and a following valid frame is served normally.
- R9: Writing register 0 with bit 15 set shows bit 15 on the strobe, and bit 15 of register 0 clears on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock, may stop when the bus is idle |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | ADDR_BITS | Device address strap, captured during reset |
| mdio_i | input | 1 | Data line as seen by the slave |
| mdio_o | output | 1 | Data driven onto the line when enabled |
| mdio_oe | output | 1 | High while the slave drives the line |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 5 | Register address of the write |
| wr_data | output | 16 | Data of the write |
| host_raddr | input | 5 | Host read port address |
| host_rdata | output | 16 | Host read port data, combinational |

## Verification
The embedded assertions check on every cycle that the line is driven only during a matching read and starts with a zero. They also check that a write strobe never coincides with driving the line, that a non-matching frame stays quiet, and that the soft-reset bit of register 0 lasts one cycle. Only the bench scenarios can show the frame-level behaviour. This covers the blind edge after reset, rejection of a 31-bit preamble, bit-exact read data and write capture, and the 4-bit address rule on a second instance. It also covers recovery after bad opcodes.

// File: rtl/mdio_slave.sv
module mdio_slave #(
  parameter int ADDR_BITS = 5,
  parameter int NREGS     = 32,
  parameter int DW        = 16,
  parameter int PRE_LEN   = 32
) (
  input  logic                     mdc,
  input  logic                     rst_n,
  input  logic [ADDR_BITS-1:0]     strap_addr,
  input  logic                     mdio_i,
  output logic                     mdio_o,
  output logic                     mdio_oe,
  output logic                     wr_en,
  output logic [$clog2(NREGS)-1:0] wr_addr,
  output logic [DW-1:0]            wr_data,
  input  logic [$clog2(NREGS)-1:0] host_raddr,
  output logic [DW-1:0]            host_rdata
);
  localparam int RAW  = $clog2(NREGS);
  localparam int FAW  = 5;
  localparam int HDR  = 2 + FAW + RAW;
  localparam int TA0  = HDR;
  localparam int TA1  = HDR + 1;
  localparam int LAST = HDR + 2 + DW - 1;
  localparam int IW   = $clog2(LAST + 1);
  localparam int CW   = $clog2(PRE_LEN + 1);

  typedef enum logic [1:0] {S_BLIND, S_PRE, S_START, S_FRAME} st_t;

  st_t                  st;
  logic [CW-1:0]        pcnt;
  logic [IW-1:0]        idx;
  logic [HDR-2:0]       hdr;
  logic [DW-1:0]        dsr;
  logic [ADDR_BITS-1:0] phy_addr;
  logic                 is_rd, hit, addr_ok;
  logic [DW-1:0]        regs [NREGS];

  wire [HDR-1:0] hdr_next = {hdr, mdio_i};
  wire [FAW-1:0] fa       = hdr_next[RAW+FAW-1:RAW];

  generate
    if (ADDR_BITS >= FAW) begin : g_full
      assign addr_ok = (fa == phy_addr[FAW-1:0]);
    end else begin : g_narrow
      assign addr_ok = (fa[FAW-1:ADDR_BITS] == '0) && (fa[ADDR_BITS-1:0] == phy_addr);
    end
  endgenerate

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_BLIND;
      pcnt     <= '0;
      idx      <= '0;
      hdr      <= '0;
      dsr      <= '0;
      is_rd    <= 1'b0;
      hit      <= 1'b0;
      mdio_o   <= 1'b0;
      mdio_oe  <= 1'b0;
      phy_addr <= strap_addr;
    end else begin
      case (st)
        S_BLIND: begin
          st   <= S_PRE;
          pcnt <= '0;
        end
        S_PRE: begin
          if (mdio_i) begin
            if (pcnt != CW'(PRE_LEN)) pcnt <= pcnt + 1'b1;
          end else if (pcnt == CW'(PRE_LEN)) begin
            st <= S_START;
          end else begin
            pcnt <= '0;
          end
        end
        S_START: begin
          pcnt <= '0;
          idx  <= '0;
          hit  <= 1'b0;
          st   <= mdio_i ? S_FRAME : S_PRE;
        end
        default: begin
          idx <= idx + 1'b1;
          if (idx < IW'(HDR)) hdr <= hdr_next[HDR-2:0];
          if (idx == IW'(1) && !(hdr[0] ^ mdio_i)) st <= S_PRE;
          if (idx == IW'(HDR-1)) begin
            is_rd <= hdr_next[HDR-1];
            hit   <= addr_ok;
            dsr   <= regs[hdr_next[RAW-1:0]];
          end
          if (hit && is_rd) begin
            if (idx == IW'(TA0)) begin
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
            end else if (idx >= IW'(TA1) && idx < IW'(LAST)) begin
              mdio_o <= dsr[DW-1];
              dsr    <= dsr << 1;
            end else if (idx == IW'(LAST)) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
            end
          end
          if (!is_rd && idx > IW'(TA1)) dsr <= {dsr[DW-2:0], mdio_i};
          if (idx == IW'(LAST)) begin
            st   <= S_PRE;
            pcnt <= '0;
          end
        end
      endcase
    end
  end

  assign wr_en   = (st == S_FRAME) && (idx == IW'(LAST)) && hit && !is_rd;
  assign wr_addr = hdr[RAW-1:0];
  assign wr_data = {dsr[DW-2:0], mdio_i};

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end else if (regs[0][DW-1]) begin
      regs[0][DW-1] <= 1'b0;
    end
  end

  assign host_rdata = regs[host_raddr];

  assert_oe_read_hit_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (hit && is_rd && st == S_FRAME));

  assert_ta_zero_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  assert_wr_quiet_R5: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_en |-> !mdio_oe);

  assert_miss_quiet_R6: assert property (@(posedge mdc) disable iff (!rst_n)
    !hit |-> (!mdio_oe && !wr_en));

  assert_selfclear_R9: assert property (@(posedge mdc) disable iff (!rst_n)
    (regs[0][DW-1] && !wr_en) |=> !regs[0][DW-1]);
endmodule

// File: tb/sim_mdio_slave.sv
module sim_mdio_slave;
  localparam int PER = 40;

  logic mdc = 1'b0;
  logic rst_n = 1'b0;
  logic mdio_i = 1'b1;
  logic [4:0] strap0 = 5'h13;
  logic [3:0] strap1 = 4'hA;
  logic o0, oe0, we0, o1, oe1, we1;
  logic [4:0] wa0, wa1, hr0, hr1;
  logic [15:0] wd0, wd1, hd0, hd1;

  always #(PER/2) mdc = ~mdc;

  mdio_slave #(.ADDR_BITS(5)) u0 (
    .mdc(mdc), .rst_n(rst_n), .strap_addr(strap0), .mdio_i(mdio_i),
    .mdio_o(o0), .mdio_oe(oe0), .wr_en(we0), .wr_addr(wa0), .wr_data(wd0),
    .host_raddr(hr0), .host_rdata(hd0));

  mdio_slave #(.ADDR_BITS(4)) u1 (
    .mdc(mdc), .rst_n(rst_n), .strap_addr(strap1), .mdio_i(mdio_i),
    .mdio_o(o1), .mdio_oe(oe1), .wr_en(we1), .wr_addr(wa1), .wr_data(wd1),
    .host_raddr(hr1), .host_rdata(hd1));

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit sel0 = 0, sel1 = 0;
  string req = "R1";
  logic [15:0] ref0 [32];
  logic [15:0] ref1 [32];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic eoe, input logic eo,
                          input logic ewr, input logic [15:0] ewd, input logic [4:0] ewa);
    mdio_i = b;
    #(PER/4);
    chk(we0 == (sel0 & ewr), "u0 strobe", we0, sel0 & ewr);
    if (sel0 & ewr) begin
      chk(wd0 == ewd, "u0 strobe data", wd0, ewd);
      chk(wa0 == ewa, "u0 strobe addr", wa0, ewa);
    end
    chk(we1 == (sel1 & ewr), "u1 strobe", we1, sel1 & ewr);
    if (sel1 & ewr) begin
      chk(wd1 == ewd, "u1 strobe data", wd1, ewd);
      chk(wa1 == ewa, "u1 strobe addr", wa1, ewa);
    end
    @(posedge mdc);
    #(PER/4);
    chk(oe0 == (sel0 & eoe), "u0 enable", oe0, sel0 & eoe);
    if (sel0 & eoe) chk(o0 == eo, "u0 data out", o0, eo);
    chk(oe1 == (sel1 & eoe), "u1 enable", oe1, sel1 & eoe);
    if (sel1 & eoe) chk(o1 == eo, "u1 data out", o1, eo);
    @(negedge mdc);
  endtask

  task automatic idle_bit();
    send_bit(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input int npre, input bit h0, input bit h1);
    logic [15:0] d;
    sel0 = h0;
    sel1 = h1;
    for (int i = 0; i < npre; i++) idle_bit();
    send_bit(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
    send_bit(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
    for (int i = 1; i >= 0; i--) send_bit(op[i], 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
    for (int i = 4; i >= 0; i--) send_bit(pa[i], 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
    for (int i = 4; i >= 0; i--) send_bit(ra[i], 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
    if (op == 2'b10) begin
      d = h0 ? ref0[ra] : (h1 ? ref1[ra] : 16'h0);
      send_bit(1'b1, 1'b1, 1'b0, 1'b0, 16'h0, 5'h0);
      for (int j = 15; j >= 1; j--) send_bit(1'b1, 1'b1, d[j], 1'b0, 16'h0, 5'h0);
      send_bit(1'b1, 1'b1, d[0], 1'b0, 16'h0, 5'h0);
    end else if (op == 2'b01) begin
      send_bit(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
      send_bit(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
      for (int j = 15; j >= 1; j--) send_bit(wd[j], 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
      send_bit(wd[0], 1'b0, 1'b0, 1'b1, wd, ra);
      if (h0) begin ref0[ra] = wd; if (ra == 5'd0) ref0[0][15] = 1'b0; end
      if (h1) begin ref1[ra] = wd; if (ra == 5'd0) ref1[0][15] = 1'b0; end
    end else begin
      for (int j = 0; j < 18; j++) idle_bit();
    end
    if (op != 2'b01) idle_bit();
    sel0 = 0;
    sel1 = 0;
    idle_bit();
  endtask

  task automatic host_chk(input bit inst, input logic [4:0] a, input logic [15:0] exp);
    if (!inst) begin hr0 = a; #1; chk(hd0 == exp, "u0 host read", hd0, exp); end
    else begin hr1 = a; #1; chk(hd1 == exp, "u1 host read", hd1, exp); end
  endtask

  initial begin
    #(PER*200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired during %s", req);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin ref0[i] = 16'h0; ref1[i] = 16'h0; end
    hr0 = 5'd0;
    hr1 = 5'd0;
    repeat (3) @(negedge mdc);
    req = "R1";
    chk(oe0 == 1'b0, "u0 enable in reset", oe0, 0);
    chk(oe1 == 1'b0, "u1 enable in reset", oe1, 0);
    host_chk(0, 5'd3, 16'h0);
    host_chk(1, 5'd7, 16'h0);
    rst_n = 1'b1;

    req = "R2";
    frame(2'b10, 5'h13, 5'd0, 16'h0, 32, 0, 0);

    req = "R5";
    frame(2'b01, 5'h13, 5'd3, 16'hA5C3, 32, 1, 0);
    host_chk(0, 5'd3, 16'hA5C3);
    frame(2'b01, 5'h13, 5'd31, 16'h5A3C, 40, 1, 0);
    host_chk(0, 5'd31, 16'h5A3C);

    req = "R4";
    frame(2'b10, 5'h13, 5'd3, 16'h0, 32, 1, 0);
    frame(2'b10, 5'h13, 5'd31, 16'h0, 32, 1, 0);
    frame(2'b10, 5'h13, 5'd9, 16'h0, 32, 1, 0);

    req = "R6";
    frame(2'b01, 5'h12, 5'd4, 16'hFFFF, 32, 0, 0);
    host_chk(0, 5'd4, 16'h0);
    frame(2'b10, 5'h03, 5'd3, 16'h0, 32, 0, 0);

    req = "R7";
    frame(2'b01, 5'h0A, 5'd7, 16'h1234, 32, 0, 1);
    host_chk(1, 5'd7, 16'h1234);
    frame(2'b10, 5'h0A, 5'd7, 16'h0, 32, 0, 1);
    frame(2'b10, 5'h1A, 5'd7, 16'h0, 32, 0, 0);
    frame(2'b01, 5'h1A, 5'd7, 16'hBEEF, 32, 0, 0);
    host_chk(1, 5'd7, 16'h1234);

    req = "R3";
    send_bit(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
    frame(2'b10, 5'h13, 5'd3, 16'h0, 31, 0, 0);
    send_bit(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 5'h0);
    frame(2'b01, 5'h13, 5'd3, 16'h0F0F, 31, 0, 0);
    host_chk(0, 5'd3, 16'hA5C3);

    req = "R8";
    frame(2'b11, 5'h13, 5'd3, 16'h0, 32, 0, 0);
    frame(2'b00, 5'h13, 5'd3, 16'h0, 32, 0, 0);
    frame(2'b10, 5'h13, 5'd3, 16'h0, 32, 1, 0);

    req = "R9";
    frame(2'b01, 5'h13, 5'd0, 16'h8005, 32, 1, 0);
    host_chk(0, 5'd0, 16'h0005);
    frame(2'b10, 5'h13, 5'd0, 16'h0, 32, 1, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule